// File: doc/BRIEF.md
# Hierarchical Carry-Lookahead Adder

This block is a purely combinational binary adder. It takes two unsigned operands of a parameterised width and a single carry-in bit. It returns the sum word and the carry that leaves the most significant position. The carry is not passed bit by bit along a chain. Each operand bit pair makes a local generate term (both bits set) and a local propagate term (either bit set). Lookahead units each take four such pairs. Every unit returns a group-generate and a group-propagate, and it receives the carry that enters it.

The lookahead units form a tree. The units at one level treat the group terms of the level below as their own inputs. This repeats until a single unit remains at the root, and the root takes the external carry-in. Carries then flow back down the tree. Each unit expands, in parallel, the carry into each of its four children. For 32 bits there are three levels: eight units, then two, then one.

A level whose input count is not a multiple of four is padded with neutral slots. A neutral slot never generates a carry and always passes one on. Because of this, any width works. The default is 32, and the intended use is a multiple of four. There are no registers, so the outputs follow the inputs after the logic delay alone.

Top module: `claAdder`

## Requirements
- R1: For every operand pair and carry-in, the value {carryOut, sumOut} equals opA + opB + carryIn computed at WIDTH+1 bits.
- R2: A position where both operand bits are 1 sends a carry into the next position whatever carry enters it. For example, 1 + 1 + 1 gives sumOut = 3.
- R3: The carry into position i+1 is 1 exactly when position i generates, or when position i propagates (at least one operand bit is 1) and a carry enters position i. This rule also holds at every 4-bit group boundary.
- R4: Sum bit i is opA[i] XOR opB[i] XOR (carry into bit i). This includes positions where both operand bits are 1. For example, all-ones + all-ones + 1 gives sumOut all ones and carryOut 1.
- R5: A carry entering a run of positions that all propagate but do not generate passes through the whole run. A position where both operand bits are 0 stops it: all-ones + 0 + 1 gives sumOut 0 and carryOut 1.
- R6: A carry generated in any 4-bit group k reaches every higher group that fully propagates. For example, all-ones + (1 << 4k) with carryIn 0 gives sumOut with bits below 4k set and carryOut 1.
- R7: carryOut is the carry leaving the top group. 0x80000000 + 0x80000000 gives carryOut 1 and sumOut 0. 0x80000000 + 0x7FFFFFFF gives carryOut 0.
- R8: The block holds no state. A new operand set presented in each cycle yields its own result within the same cycle, with no dependence on the previous operands.
- R9: Zero operands give sumOut equal to carryIn and carryOut 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First addend |
| opB | input | WIDTH | Second addend |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | WIDTH | Sum word |
| carryOut | output | 1 | Carry leaving the top bit |

## Verification
The hardest case to reach is a long propagate run that crosses every group boundary and is started by a generate in one chosen group. Random operands almost never produce a run of twenty or more propagating positions, so the upper lookahead levels would rarely have to carry a signal the whole way. The stimulus builds these cases directly. For each group in turn, it adds a single set bit at that group's lowest position to an all-ones word. It also opens a hole of two zero bits inside each group to show the run stopping there. Alternating patterns, all-ones cases and a large random set then cover the rest.

// File: rtl/claPkg.sv
package claPkg;
  localparam int GroupSize = 4;

  function automatic int groupCount(input int n);
    return (n + GroupSize - 1) / GroupSize;
  endfunction
endpackage

// File: rtl/claGenProp.sv
module claGenProp #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [WIDTH-1:0] bitGen,
  output logic [WIDTH-1:0] bitProp
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign bitGen[i]  = opA[i] & opB[i];
    assign bitProp[i] = opA[i] | opB[i];
  end
endmodule

// File: rtl/claGroupUnit.sv
module claGroupUnit (
  input  logic [3:0] genIn,
  input  logic [3:0] propIn,
  input  logic       carryEnter,
  output logic [3:0] childCarry,
  output logic       groupGen,
  output logic       groupProp
);
  always_comb begin
    childCarry[0] = carryEnter;
    childCarry[1] = genIn[0] | (propIn[0] & carryEnter);
    childCarry[2] = genIn[1] | (propIn[1] & genIn[0])
                  | (propIn[1] & propIn[0] & carryEnter);
    childCarry[3] = genIn[2] | (propIn[2] & genIn[1])
                  | (propIn[2] & propIn[1] & genIn[0])
                  | (propIn[2] & propIn[1] & propIn[0] & carryEnter);
    groupGen  = genIn[3] | (genIn[2] & propIn[3])
              | (genIn[1] & propIn[2] & propIn[3])
              | (genIn[0] & propIn[1] & propIn[2] & propIn[3]);
    groupProp = propIn[0] & propIn[1] & propIn[2] & propIn[3];
  end

  // R3: the flat expansion agrees with the step-by-step carry rule
  always_comb begin
    for (int k = 0; k < 3; k++) begin
      a_r3_group_ripple: assert (childCarry[k+1] == (genIn[k] | (propIn[k] & childCarry[k])))
        else $error("group ripple mismatch at child %0d", k);
    end
  end

  // R6: the group terms give the same carry out as the last child step
  always_comb begin
    a_r6_group_out: assert ((groupGen | (groupProp & carryEnter))
                            == (genIn[3] | (propIn[3] & childCarry[3])))
      else $error("group carry-out disagrees with last child");
  end
endmodule

// File: rtl/claTree.sv
module claTree #(
  parameter int N = 32
) (
  input  logic [N-1:0] genIn,
  input  logic [N-1:0] propIn,
  input  logic         carryEnter,
  output logic [N-1:0] carryInto,
  output logic         treeGen,
  output logic         treeProp
);
  import claPkg::*;
  localparam int Units = groupCount(N);
  localparam int PadN  = Units * GroupSize;

  logic [PadN-1:0]  genPad;
  logic [PadN-1:0]  propPad;
  logic [PadN-1:0]  carryPad;
  logic [Units-1:0] unitGen;
  logic [Units-1:0] unitProp;
  logic [Units-1:0] unitCarry;

  for (genvar i = 0; i < PadN; i++) begin : g_pad
    if (i < N) begin : g_real
      assign genPad[i]  = genIn[i];
      assign propPad[i] = propIn[i];
    end else begin : g_neutral
      assign genPad[i]  = 1'b0;
      assign propPad[i] = 1'b1;
    end
  end

  for (genvar u = 0; u < Units; u++) begin : g_unit
    claGroupUnit u_grp (
      .genIn      (genPad[GroupSize*u +: GroupSize]),
      .propIn     (propPad[GroupSize*u +: GroupSize]),
      .carryEnter (unitCarry[u]),
      .childCarry (carryPad[GroupSize*u +: GroupSize]),
      .groupGen   (unitGen[u]),
      .groupProp  (unitProp[u])
    );
  end

  assign carryInto = carryPad[N-1:0];

  if (Units == 1) begin : g_root
    assign unitCarry[0] = carryEnter;
    assign treeGen      = unitGen[0];
    assign treeProp     = unitProp[0];
  end else begin : g_upper
    claTree #(.N(Units)) u_upper (
      .genIn      (unitGen),
      .propIn     (unitProp),
      .carryEnter (carryEnter),
      .carryInto  (unitCarry),
      .treeGen    (treeGen),
      .treeProp   (treeProp)
    );
  end

  // R6: carry leaving unit u, from its group terms, is what the level above hands unit u+1
  always_comb begin
    for (int u = 0; u + 1 < Units; u++) begin
      a_r6_group_chain: assert ((unitGen[u] | (unitProp[u] & unitCarry[u])) == unitCarry[u+1])
        else $error("group chain broken between units %0d and %0d", u, u + 1);
    end
  end

  // R5: neutral pad slots pass their carry on unchanged
  always_comb begin
    for (int i = N; i < PadN; i++) begin
      a_r5_pad_transparent: assert (carryPad[i] == (genPad[i-1] | (propPad[i-1] & carryPad[i-1])))
        else $error("pad slot %0d altered the carry", i);
    end
  end
endmodule

// File: rtl/claSumStage.sv
module claSumStage #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH-1:0] carryInto,
  output logic [WIDTH-1:0] sumOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_sum
    assign sumOut[i] = opA[i] ^ opB[i] ^ carryInto[i];
  end

  // R3: carries from the lookahead tree obey the per-bit carry rule
  always_comb begin
    for (int i = 0; i + 1 < WIDTH; i++) begin
      a_r3_bit_ripple: assert (carryInto[i+1] == ((opA[i] & opB[i]) | ((opA[i] | opB[i]) & carryInto[i])))
        else $error("bit carry rule broken at bit %0d", i);
    end
  end
endmodule

// File: rtl/claAdder.sv
module claAdder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  logic [WIDTH-1:0] bitGen;
  logic [WIDTH-1:0] bitProp;
  logic [WIDTH-1:0] carryInto;
  logic             rootGen;
  logic             rootProp;

  claGenProp #(.WIDTH(WIDTH)) u_genProp (
    .opA     (opA),
    .opB     (opB),
    .bitGen  (bitGen),
    .bitProp (bitProp)
  );

  claTree #(.N(WIDTH)) u_tree (
    .genIn      (bitGen),
    .propIn     (bitProp),
    .carryEnter (carryIn),
    .carryInto  (carryInto),
    .treeGen    (rootGen),
    .treeProp   (rootProp)
  );

  claSumStage #(.WIDTH(WIDTH)) u_sum (
    .opA       (opA),
    .opB       (opB),
    .carryInto (carryInto),
    .sumOut    (sumOut)
  );

  assign carryOut = rootGen | (rootProp & carryIn);

  // R1: full result agrees with a wide arithmetic sum
  logic [WIDTH:0] refTotal;
  always_comb begin
    refTotal = {1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn};
    a_r1_total: assert ({carryOut, sumOut} == refTotal)
      else $error("total mismatch");
  end

  // R7: root carry-out equals the carry leaving the top bit position
  always_comb begin
    a_r7_top_carry: assert (carryOut == ((opA[WIDTH-1] & opB[WIDTH-1])
                            | ((opA[WIDTH-1] | opB[WIDTH-1]) & carryInto[WIDTH-1])))
      else $error("carry-out disagrees with top bit");
  end
endmodule

// File: tb/claAdder_tb.sv
`timescale 1ns/1ps
module claAdder_tb;
  localparam int W = 32;
  localparam int Groups = W / 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] opA = '0;
  logic [W-1:0] opB = '0;
  logic         carryIn = 1'b0;
  logic [W-1:0] sumOut;
  logic         carryOut;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic         ci;
    logic [W:0]   expTotal;
    string        tag;
  } sbItem;

  sbItem sbQ[$];
  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  claAdder #(.WIDTH(W)) u_dut (
    .opA      (opA),
    .opB      (opB),
    .carryIn  (carryIn),
    .sumOut   (sumOut),
    .carryOut (carryOut)
  );

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic ci, input string tag);
    sbItem it;
    @(negedge clk);
    opA = a;
    opB = b;
    carryIn = ci;
    it.a = a;
    it.b = b;
    it.ci = ci;
    it.expTotal = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    it.tag = tag;
    sbQ.push_back(it);
  endtask

  // monitor: results sampled at the rising edge, half a cycle after the drive
  always @(posedge clk) begin
    if (rstN && sbQ.size() > 0) begin
      sbItem it;
      it = sbQ.pop_front();
      checks++;
      if ({carryOut, sumOut} !== it.expTotal) begin
        failures++;
        $display("FAIL %s a=%h b=%h ci=%0d got cout=%0d sum=%h exp cout=%0d sum=%h",
                 it.tag, it.a, it.b, it.ci, carryOut, sumOut,
                 it.expTotal[W], it.expTotal[W-1:0]);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: zero operands during reset give zero result
    checks++;
    if (sumOut !== '0 || carryOut !== 1'b0) begin
      failures++;
      $display("FAIL R9 reset got cout=%0d sum=%h exp cout=0 sum=0", carryOut, sumOut);
    end
    rstN = 1'b1;

    drive('0, '0, 1'b0, "R9 zero");
    drive('0, '0, 1'b1, "R9 zero+cin");
    drive(32'h1, 32'h1, 1'b1, "R2 generate");
    drive(32'h0000_00F0, 32'h0000_00F0, 1'b0, "R2 generate nibble");
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b0, "R3 alternating");
    drive(32'hAAAA_AAAA, 32'h5555_5555, 1'b1, "R3 alternating+cin");
    drive(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1, "R3 alternating same");
    drive('1, '1, 1'b1, "R4 ones+ones+cin");
    drive('1, '1, 1'b0, "R4 ones+ones");
    drive('1, '0, 1'b1, "R5 full propagate");
    drive('1, 32'h1, 1'b0, "R5 ones+one");
    drive(32'h8000_0000, 32'h8000_0000, 1'b0, "R7 msb carry");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 1'b0, "R7 no carry");
    drive(32'h8000_0000, 32'h7FFF_FFFF, 1'b1, "R7 carry via chain");

    for (int k = 0; k < Groups; k++) begin
      drive('1, 32'h1 << (4 * k), 1'b0, "R6 group generate");
      drive(~(32'h3 << (4 * k + 1)), 32'h1, 1'b0, "R5 propagate hole");
      drive(~(32'h1 << (4 * k + 3)), '0, 1'b1, "R5 stop at group top");
    end

    // R8: operands change every cycle, each result checked on its own
    for (int n = 0; n < 16; n++) begin
      drive((n % 2 == 0) ? '1 : '0, (n % 2 == 0) ? 32'h1 : '0, n[0], "R8 alternating load");
    end

    for (int n = 0; n < 1500; n++) begin
      drive($urandom, $urandom, 1'($urandom), "R1 random");
    end

    while (sbQ.size() > 0) @(posedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule